// File: doc/BRIEF.md
# Page Usage Tracker

This block records how the entries of a 64-entry page translation cache are used. It keeps two 64-bit vectors with one bit per cache entry. The first vector records that the page held in an entry has been touched. The second records that the page has been written. The translation block reports each hit with an entry index, a write flag and a qualifier that says whether the access was made in mapped user state. Only qualified hits set bits.

Software reads and writes both vectors over a supervisor register port. Each vector appears as four 16-bit registers. A single write to a dedicated address wipes a whole vector. Software scans the touched vector from time to time, bumps its usage counts in memory, and then clears it. It reads the written vector before it evicts a page, to learn whether the page must be copied back.

The hit input is a plain strobe with no back-pressure: the tracker takes one hit in every cycle in which `hit_valid` is high. The register port has no handshake. Writes take effect at the clock edge, and read data is combinational on the current state.

Top module: `pat_tracker`

## Requirements
- R1: After reset, all 64 touched bits and all 64 written bits read 0.
- R2: A hit with `hit_valid`=1 and `hit_mapped_user`=1 sets the touched bit of entry `hit_idx`. The bit is readable from the cycle after the clock edge.
- R3: A qualified hit that also has `hit_write`=1 sets the written bit of entry `hit_idx` as well as its touched bit. A qualified hit with `hit_write`=0 leaves the written vector unchanged.
- R4: A hit with `hit_mapped_user`=0 changes neither vector.
- R5: Register selection uses `reg_addr[19:12]`. Codes 0x80 to 0x83 select touched registers 0 to 3. Codes 0x85 to 0x88 select written registers 0 to 3. Entry i maps to bit i mod 16 of register i div 16.
- R6: While `reg_en`=1 and `reg_we`=0, `reg_rdata` shows the selected register in the same cycle. It shows 0 for any other code, including 0x84 and 0x89, and it shows 0 whenever no read is in progress.
- R7: A write to a register code replaces all 16 bits of that register with `reg_wdata`, so it sets and clears individual bits.
- R8: A write to code 0x84 clears the whole touched vector, and a write to code 0x89 clears the whole written vector. Each leaves the other vector unchanged.
- R9: When a qualified hit and a software write or clear affect the same bit in the same cycle, the bit ends up set.
- R10: Writes to codes outside 0x80 to 0x89 change neither vector.
- R11: Address bits 11:0 play no part in selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | 1 | A cache hit is reported in this cycle |
| hit_mapped_user | input | 1 | The hit was made in mapped user state |
| hit_write | input | 1 | The hit was a write |
| hit_idx | input | 6 | Index of the cache entry that hit |
| reg_en | input | 1 | Register port access in this cycle |
| reg_we | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 20 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data |

## Verification
The assertions assume that the hit inputs and the register inputs hold steady and are known at each rising edge. They also assume that `hit_idx` is only meaningful while `hit_valid` is high, so no assertion looks at `hit_idx` in other cycles. The bench drives all inputs at the falling edge, so every value is settled well before the sampling edge. It draws addresses from the ten decoded codes plus codes just outside that range, and it randomises the low address bits, so that both the decoded writes and the ignored writes occur often alongside qualified and unqualified hits.

// File: rtl/pat_pkg.sv
package pat_pkg;
  localparam int unsigned ENTRIES_DEF  = 64;
  localparam int unsigned REG_W_DEF    = 16;
  localparam int unsigned ADDR_W_DEF   = 20;
  localparam int unsigned SEL_LSB_DEF  = 12;
  localparam int unsigned SEL_BASE_DEF = 'h80;

  typedef struct packed {
    logic touch_reg;
    logic dirty_reg;
    logic touch_clr;
    logic dirty_clr;
  } pat_sel_t;
endpackage

// File: rtl/pat_decode.sv
module pat_decode
  import pat_pkg::*;
#(
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned SEL_LSB  = SEL_LSB_DEF,
  parameter int unsigned SEL_BASE = SEL_BASE_DEF,
  parameter int unsigned NREG     = 4,
  localparam int unsigned SEL_W   = ADDR_W - SEL_LSB,
  localparam int unsigned RI_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output pat_sel_t          sel,
  output logic [RI_W-1:0]   reg_idx
);
  logic [SEL_W-1:0] code;
  int               off;

  assign code = addr[ADDR_W-1:SEL_LSB];

  always_comb begin
    off           = int'(code) - int'(SEL_BASE);
    sel.touch_reg = (off >= 0) && (off < int'(NREG));
    sel.touch_clr = (off == int'(NREG));
    sel.dirty_reg = (off > int'(NREG)) && (off <= 2 * int'(NREG));
    sel.dirty_clr = (off == 2 * int'(NREG) + 1);
    if (sel.dirty_reg) reg_idx = RI_W'(off - int'(NREG) - 1);
    else               reg_idx = RI_W'(off);
  end
endmodule

// File: rtl/pat_vec.sv
module pat_vec #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned REG_W   = 16,
  localparam int unsigned NREG   = ENTRIES / REG_W,
  localparam int unsigned IX_W   = $clog2(ENTRIES),
  localparam int unsigned RI_W   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [IX_W-1:0]    set_idx,
  input  logic               wr_en,
  input  logic [RI_W-1:0]    wr_reg,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               clr_all,
  input  logic [RI_W-1:0]    rd_reg,
  output logic [REG_W-1:0]   rd_data,
  output logic [ENTRIES-1:0] vec
);
  logic [ENTRIES-1:0] nxt_vec;

  for (genvar r = 0; r < int'(NREG); r++) begin : g_reg
    logic [REG_W-1:0] nxt;
    always_comb begin
      nxt = clr_all ? '0 : vec[r*REG_W +: REG_W];
      if (wr_en && (wr_reg == RI_W'(r))) nxt = wr_data;
      // a hardware set is applied last so that it wins over software
      for (int b = 0; b < int'(REG_W); b++) begin
        if (set_en && (set_idx == IX_W'(r * int'(REG_W) + b))) nxt[b] = 1'b1;
      end
    end
    assign nxt_vec[r*REG_W +: REG_W] = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec <= '0;
    else        vec <= nxt_vec;
  end

  assign rd_data = vec[rd_reg*REG_W +: REG_W];
endmodule

// File: rtl/pat_tracker.sv
module pat_tracker
  import pat_pkg::*;
#(
  parameter int unsigned ENTRIES  = ENTRIES_DEF,
  parameter int unsigned REG_W    = REG_W_DEF,
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned SEL_LSB  = SEL_LSB_DEF,
  parameter int unsigned SEL_BASE = SEL_BASE_DEF,
  localparam int unsigned NREG    = ENTRIES / REG_W,
  localparam int unsigned IX_W    = $clog2(ENTRIES),
  localparam int unsigned RI_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_valid,
  input  logic              hit_mapped_user,
  input  logic              hit_write,
  input  logic [IX_W-1:0]   hit_idx,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  pat_sel_t           sel;
  logic [RI_W-1:0]    reg_idx;
  logic               hit_q;
  logic               wr_cyc;
  logic               rd_cyc;
  logic [REG_W-1:0]   touch_rd;
  logic [REG_W-1:0]   dirty_rd;
  logic [ENTRIES-1:0] touch_vec;
  logic [ENTRIES-1:0] dirty_vec;

  assign hit_q  = hit_valid && hit_mapped_user;
  assign wr_cyc = reg_en && reg_we;
  assign rd_cyc = reg_en && !reg_we;

  pat_decode #(
    .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB), .SEL_BASE(SEL_BASE), .NREG(NREG)
  ) u_dec (
    .addr(reg_addr), .sel(sel), .reg_idx(reg_idx)
  );

  pat_vec #(.ENTRIES(ENTRIES), .REG_W(REG_W)) u_touch (
    .clk(clk), .rst_n(rst_n),
    .set_en(hit_q), .set_idx(hit_idx),
    .wr_en(wr_cyc && sel.touch_reg), .wr_reg(reg_idx), .wr_data(reg_wdata),
    .clr_all(wr_cyc && sel.touch_clr),
    .rd_reg(reg_idx), .rd_data(touch_rd), .vec(touch_vec)
  );

  pat_vec #(.ENTRIES(ENTRIES), .REG_W(REG_W)) u_dirty (
    .clk(clk), .rst_n(rst_n),
    .set_en(hit_q && hit_write), .set_idx(hit_idx),
    .wr_en(wr_cyc && sel.dirty_reg), .wr_reg(reg_idx), .wr_data(reg_wdata),
    .clr_all(wr_cyc && sel.dirty_clr),
    .rd_reg(reg_idx), .rd_data(dirty_rd), .vec(dirty_vec)
  );

  always_comb begin
    reg_rdata = '0;
    if (rd_cyc && sel.touch_reg)      reg_rdata = touch_rd;
    else if (rd_cyc && sel.dirty_reg) reg_rdata = dirty_rd;
  end
endmodule

// File: rtl/pat_tracker_chk.sv
module pat_tracker_chk #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned ADDR_W  = 20,
  localparam int unsigned IX_W   = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hit_valid,
  input logic               hit_mapped_user,
  input logic               hit_write,
  input logic [IX_W-1:0]    hit_idx,
  input logic               reg_en,
  input logic               reg_we,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [ENTRIES-1:0] touch_vec,
  input logic [ENTRIES-1:0] dirty_vec
);
  logic q_hit;
  logic sw_wr;
  assign q_hit = hit_valid && hit_mapped_user;
  assign sw_wr = reg_en && reg_we;

  p_hit_sets_touch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q_hit |=> touch_vec[$past(hit_idx)]);

  p_write_sets_dirty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_hit && hit_write) |=> dirty_vec[$past(hit_idx)]);

  p_idle_keeps_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_hit && !sw_wr) |=> ($stable(touch_vec) && $stable(dirty_vec)));

  p_touch_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && reg_addr[19:12] == 8'h84 && !q_hit) |=> (touch_vec == '0));

  p_dirty_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && reg_addr[19:12] == 8'h89 && !(q_hit && hit_write)) |=> (dirty_vec == '0));

  p_outside_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && (reg_addr[19:12] < 8'h80 || reg_addr[19:12] > 8'h89) && !q_hit)
      |=> ($stable(touch_vec) && $stable(dirty_vec)));
endmodule

bind pat_tracker pat_tracker_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid),
  .hit_mapped_user(hit_mapped_user), .hit_write(hit_write), .hit_idx(hit_idx),
  .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
  .touch_vec(touch_vec), .dirty_vec(dirty_vec)
);

// File: tb/tb_pat_tracker.sv
module tb_pat_tracker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hit_valid = 1'b0, hit_mapped_user = 1'b0, hit_write = 1'b0;
  logic [5:0]  hit_idx = '0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [19:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  logic [63:0] touch_m = '0;
  logic [63:0] dirty_m = '0;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pat_tracker dut (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_mapped_user(hit_mapped_user),
    .hit_write(hit_write), .hit_idx(hit_idx), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [15:0] expect_read(input logic [19:0] a);
    int c = int'(a[19:12]);
    if (c >= 'h80 && c <= 'h83) return touch_m[(c-'h80)*16 +: 16];
    if (c >= 'h85 && c <= 'h88) return dirty_m[(c-'h85)*16 +: 16];
    return 16'h0;
  endfunction

  task automatic model_step(input logic hv, hm, hw, input logic [5:0] hi,
                            input logic en, we, input logic [19:0] a, input logic [15:0] d);
    int c = int'(a[19:12]);
    if (en && we) begin
      if (c >= 'h80 && c <= 'h83) touch_m[(c-'h80)*16 +: 16] = d;
      if (c == 'h84) touch_m = '0;
      if (c >= 'h85 && c <= 'h88) dirty_m[(c-'h85)*16 +: 16] = d;
      if (c == 'h89) dirty_m = '0;
    end
    if (hv && hm) begin
      touch_m[hi] = 1'b1;
      if (hw) dirty_m[hi] = 1'b1;
    end
  endtask

  task automatic step(input logic hv, hm, hw, input logic [5:0] hi,
                      input logic en, we, input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    hit_valid = hv; hit_mapped_user = hm; hit_write = hw; hit_idx = hi;
    reg_en = en; reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model_step(hv, hm, hw, hi, en, we, a, d);
  endtask

  task automatic read_chk(input logic [19:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    hit_valid = 1'b0; reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, reg_rdata, exp);
    end
    reg_en = 1'b0;
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 4; k++) begin
      read_chk(20'h80000 + 20'(k) * 20'h1000, expect_read(20'h80000 + 20'(k) * 20'h1000), req);
      read_chk(20'h85000 + 20'(k) * 20'h1000, expect_read(20'h85000 + 20'(k) * 20'h1000), req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check_all("R1 reset");

    // R2/R5: entry 0 and entry 63 map to first/last bits
    step(1, 1, 0, 6'd0, 0, 0, 20'h0, 16'h0);
    step(1, 1, 0, 6'd63, 0, 0, 20'h0, 16'h0);
    read_chk(20'h80000, 16'h0001, "R2 R5 entry0");
    read_chk(20'h83000, 16'h8000, "R2 R5 entry63");
    read_chk(20'h85000, 16'h0000, "R3 no write no dirty");
    // R3 write hit
    step(1, 1, 1, 6'd17, 0, 0, 20'h0, 16'h0);
    read_chk(20'h86000, 16'h0002, "R3 dirty entry17");
    read_chk(20'h81000, 16'h0002, "R3 touch entry17");
    // R4 unmapped hit
    step(1, 0, 1, 6'd40, 0, 0, 20'h0, 16'h0);
    check_all("R4 unmapped hit ignored");
    // R7 individual write, R11 low bits ignored
    step(0, 0, 0, 6'd0, 1, 1, 20'h82abc, 16'hA5C3);
    read_chk(20'h82000, 16'hA5C3, "R7 R11 register write");
    read_chk(20'h82ffe, 16'hA5C3, "R11 read low bits");
    // R6 clear codes read 0, no read gives 0
    read_chk(20'h84000, 16'h0000, "R6 clear code read");
    read_chk(20'h89000, 16'h0000, "R6 clear code read");
    // R10 outside write
    step(0, 0, 0, 6'd0, 1, 1, 20'h8A000, 16'hFFFF);
    step(0, 0, 0, 6'd0, 1, 1, 20'h7F000, 16'hFFFF);
    check_all("R10 outside writes ignored");
    // R9 hardware wins over register write and over clear
    step(1, 1, 1, 6'd3, 1, 1, 20'h80000, 16'h0000);
    read_chk(20'h80000, 16'h0008, "R9 set beats write");
    step(1, 1, 1, 6'd20, 1, 1, 20'h89000, 16'h0000);
    read_chk(20'h86000, 16'h0010, "R9 set beats clear");
    // R8 clears leave other vector
    step(0, 0, 0, 6'd0, 1, 1, 20'h84000, 16'h0);
    check_all("R8 touch clear");
    step(0, 0, 0, 6'd0, 1, 1, 20'h89000, 16'h0);
    check_all("R8 dirty clear");

    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [7:0] code;
      int pick = int'($urandom_range(0, 11));
      code = 8'(8'h7F + pick);
      step($urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           6'($urandom_range(0, 63)), $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
           {code, 12'($urandom_range(0, 4095))}, 16'($urandom()));
      if (n % 20 == 19) check_all("R2 R3 R7 R8 R9 random");
    end
    @(negedge clk);
    reg_en = 1'b0; hit_valid = 1'b0; reg_addr = 20'h80000;
    #1;
    checks++;
    if (reg_rdata !== 16'h0) begin
      fails++;
      $display("FAIL R6 idle read actual=%h expected=0000", reg_rdata);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule